// File: doc/BRIEF.md
# Audio Codec Control Register File

This block keeps the 16-bit control words of a stereo audio codec. A link controller that has already unpacked its serial frames presents command writes (a 7-bit register address, a 16-bit data word and a one-cycle strobe) and command reads (an address and a strobe). The block stores the writable words and answers each read one cycle later. Some bits are fixed, some words are identity values, and one word echoes the codec's strap inputs.

The two mode pins and the two-bit codec ID are static inputs. Together they decide which stored word acts as the master volume and which rate word feeds the front converter pair. Because of this, the same write can mean different things on differently strapped parts. An unmute write to the surround volume also clears the DAC gain mute on a part strapped as ID 10, so software does not need a second write for it.

The decoded outputs go straight to the analog and rate logic: spatial enhancement enable and depth, the effective master volume word and its mute, the DAC gain mute, and the two rate words.

Top module: `codec_regfile`

## Requirements
- R1: While `rst_n` is low, and after it is released with no writes, the outputs are as follows. `master_mute` and `dac_gain_mute` are 1. `master_vol` is 8000h. `enh_enable` is 0 and `enh_depth` is 0. `dac_rate` and `adc_rate` are BB80h (48000). Register 18h reads 8808h and register 38h reads 8000h.
- R2: `enh_depth` equals bits 3:0 of the last word written to register 22h. Bits 15:4 of that register always read 0, and `enh_depth` changes only on a write to 22h.
- R3: Bit 13 of register 20h drives `enh_enable`. Bit 15 of 20h always reads 1, and writing 0 to it changes nothing. Bits 14:0 read back as written.
- R4: Register 00h always reads 6000h, which carries the identifier 24 (binary 11000) in bits 14:10. Writes to it are ignored.
- R5: Register 28h reads `{codec_id, 14'b0}`. Writes to it are ignored.
- R6: When `codec_id` is 10, `master_vol` is the word held at 38h. For any other ID it is the word held at 02h. `master_mute` is bit 15 of whichever word is selected.
- R7: A write to 38h with bit 15 equal to 0 while `codec_id` is 10 clears bit 15 of 18h one cycle later. With any other ID, such a write leaves 18h unchanged. `dac_gain_mute` is bit 15 of 18h.
- R8: `dac_rate` comes from 2Eh when `codec_id` is 10, or when `mode_pins` is 10 and `codec_id` is 01. In every other case it comes from 2Ch. `adc_rate` always comes from 32h.
- R9: A read of any address other than 00h, 02h, 18h, 20h, 22h, 28h, 2Ch, 2Eh, 32h and 38h (odd addresses included) returns 0000h. A write to such an address changes no register and no output.
- R10: `rd_valid` is high in exactly the cycle after a cycle with `rd_en` high, and `rd_data` then holds the answer for the address that was sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset, loads defaults |
| mode_pins | input | 2 | Static operating mode straps |
| codec_id | input | 2 | Static codec ID straps (00 primary) |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 7 | Write register address |
| wr_data | input | 16 | Write data word |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 7 | Read register address |
| rd_data | output | 16 | Read answer, registered |
| rd_valid | output | 1 | Read answer valid |
| enh_enable | output | 1 | Spatial enhancement enable |
| enh_depth | output | 4 | Spatial enhancement depth |
| master_vol | output | 16 | Effective master volume word |
| master_mute | output | 1 | Effective master mute |
| dac_gain_mute | output | 1 | DAC gain stage mute |
| dac_rate | output | 16 | Front DAC sample rate word |
| adc_rate | output | 16 | ADC sample rate word |

## Verification
The bench tries to clear the fixed POP bit and to overwrite the identity and ID echo words. A design that stored those writes would read them back changed. The bench moves the codec ID to and from 10 around surround writes. A wrong master source then shows the 02h word, and an override that ignores the ID clears the DAC mute on a part that is not ID 10. It also walks the mode and ID pairs that pick the front rate word. Finally it writes and reads unmapped and odd addresses, which catches a decoder that ignores the low bit, aliases a live register or returns stale data.

// File: rtl/creg_pkg.sv
package creg_pkg;
  localparam int ADDR_W = 7;
  localparam int DATA_W = 16;
  localparam int NREG   = 8;

  localparam int IX_MVOL  = 0;
  localparam int IX_DACG  = 1;
  localparam int IX_GEN   = 2;
  localparam int IX_DEPTH = 3;
  localparam int IX_RATEA = 4;
  localparam int IX_RATEB = 5;
  localparam int IX_ADCR  = 6;
  localparam int IX_SURR  = 7;

  localparam logic [ADDR_W-1:0] A_CAPS  = 7'h00;
  localparam logic [ADDR_W-1:0] A_GEN   = 7'h20;
  localparam logic [ADDR_W-1:0] A_EXTID = 7'h28;

  localparam int MUTE_BIT = 15;
  localparam int POP_BIT  = 15;
  localparam int ENH_BIT  = 13;
  localparam int DEPTH_W  = 4;
  localparam logic [1:0] ID_SURR = 2'b10;
  localparam logic [1:0] ID_CTR  = 2'b01;
  localparam logic [1:0] MODE_QUAD = 2'b10;

  function automatic logic [ADDR_W-1:0] reg_addr(input int i);
    case (i)
      IX_MVOL:  return 7'h02;
      IX_DACG:  return 7'h18;
      IX_GEN:   return 7'h20;
      IX_DEPTH: return 7'h22;
      IX_RATEA: return 7'h2C;
      IX_RATEB: return 7'h2E;
      IX_ADCR:  return 7'h32;
      default:  return 7'h38;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] reg_default(input int i);
    case (i)
      IX_MVOL:  return 16'h8000;
      IX_DACG:  return 16'h8808;
      IX_GEN:   return 16'h0000;
      IX_DEPTH: return 16'h0000;
      IX_RATEA, IX_RATEB, IX_ADCR: return 16'hBB80;
      default:  return 16'h8000;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] reg_wmask(input int i);
    case (i)
      IX_GEN:   return 16'h7FFF;
      IX_DEPTH: return 16'h000F;
      default:  return 16'hFFFF;
    endcase
  endfunction

  // identity word: enhancement code 24 placed in bits 14:10
  function automatic logic [DATA_W-1:0] caps_word();
    logic [DATA_W-1:0] w;
    w = '0;
    w[14:10] = 5'd24;
    return w;
  endfunction

  function automatic logic [DATA_W-1:0] extid_word(input logic [1:0] id);
    return {id, {(DATA_W-2){1'b0}}};
  endfunction

  // 1 selects the alternate front rate word
  function automatic logic use_alt_rate(input logic [1:0] mode, input logic [1:0] id);
    return (id == ID_SURR) || (mode == MODE_QUAD && id == ID_CTR);
  endfunction
endpackage

// File: rtl/creg_decode.sv
module creg_decode
  import creg_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  output logic [NREG-1:0]   hit
);
  for (genvar i = 0; i < NREG; i++) begin : g_hit
    assign hit[i] = (addr == reg_addr(i));
  end
endmodule

// File: rtl/creg_store.sv
module creg_store
  import creg_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [NREG-1:0]        wr_hit,
  input  logic [DATA_W-1:0]      wr_data,
  input  logic [1:0]             codec_id,
  output logic [NREG*DATA_W-1:0] regs_flat,
  output logic                   ovr_evt
);
  assign ovr_evt = wr_en && wr_hit[IX_SURR] && !wr_data[MUTE_BIT] && (codec_id == ID_SURR);

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    logic [DATA_W-1:0] q;
    if (i == IX_DACG) begin : g_ovr
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= reg_default(i);
        else if (wr_en && wr_hit[i]) q <= (q & ~reg_wmask(i)) | (wr_data & reg_wmask(i));
        else if (ovr_evt) q[MUTE_BIT] <= 1'b0;
      end
    end else begin : g_plain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= reg_default(i);
        else if (wr_en && wr_hit[i]) q <= (q & ~reg_wmask(i)) | (wr_data & reg_wmask(i));
      end
    end
    assign regs_flat[i*DATA_W +: DATA_W] = q;
  end

  // R7: unmuting the surround word on an ID 10 part releases the DAC gain mute
  a_r7_mute_override: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_evt |=> !regs_flat[IX_DACG*DATA_W + MUTE_BIT]);
endmodule

// File: rtl/creg_readmux.sv
module creg_readmux
  import creg_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   rd_en,
  input  logic [ADDR_W-1:0]      rd_addr,
  input  logic [NREG-1:0]        rd_hit,
  input  logic [NREG*DATA_W-1:0] regs_flat,
  input  logic [1:0]             codec_id,
  output logic [DATA_W-1:0]      rd_data,
  output logic                   rd_valid
);
  logic [DATA_W-1:0] word;
  logic              known;
  logic [ADDR_W-1:0] last_addr;
  logic              last_known;

  always_comb begin
    word = '0;
    for (int i = 0; i < NREG; i++)
      if (rd_hit[i]) word = regs_flat[i*DATA_W +: DATA_W];
    if (rd_addr == A_GEN)   word[POP_BIT] = 1'b1;
    if (rd_addr == A_CAPS)  word = caps_word();
    if (rd_addr == A_EXTID) word = extid_word(codec_id);
    known = (|rd_hit) || (rd_addr == A_CAPS) || (rd_addr == A_EXTID);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data    <= '0;
      rd_valid   <= 1'b0;
      last_addr  <= '0;
      last_known <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) begin
        rd_data    <= word;
        last_addr  <= rd_addr;
        last_known <= known;
      end
    end
  end

  // R3: the POP bit never reads back as 0
  a_r3_pop_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && last_addr == A_GEN) |-> rd_data[POP_BIT]);
  // R9: unmapped addresses answer zero
  a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !last_known) |-> (rd_data == '0));
  // R10: one-cycle read answer
  a_r10_read_latency: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);
endmodule

// File: rtl/codec_regfile.sv
module codec_regfile
  import creg_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          mode_pins,
  input  logic [1:0]          codec_id,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic                rd_en,
  input  logic [ADDR_W-1:0]   rd_addr,
  output logic [DATA_W-1:0]   rd_data,
  output logic                rd_valid,
  output logic                enh_enable,
  output logic [DEPTH_W-1:0]  enh_depth,
  output logic [DATA_W-1:0]   master_vol,
  output logic                master_mute,
  output logic                dac_gain_mute,
  output logic [DATA_W-1:0]   dac_rate,
  output logic [DATA_W-1:0]   adc_rate
);
  logic [NREG-1:0]        wr_hit;
  logic [NREG-1:0]        rd_hit;
  logic [NREG*DATA_W-1:0] regs_flat;
  logic                   ovr_evt;
  logic                   surr_is_master;

  creg_decode u_wdec (.addr(wr_addr), .hit(wr_hit));
  creg_decode u_rdec (.addr(rd_addr), .hit(rd_hit));

  creg_store u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_hit(wr_hit),
    .wr_data(wr_data), .codec_id(codec_id),
    .regs_flat(regs_flat), .ovr_evt(ovr_evt));

  creg_readmux u_rmux (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_hit(rd_hit), .regs_flat(regs_flat), .codec_id(codec_id),
    .rd_data(rd_data), .rd_valid(rd_valid));

  assign surr_is_master = (codec_id == ID_SURR);
  assign master_vol     = surr_is_master ? regs_flat[IX_SURR*DATA_W +: DATA_W]
                                         : regs_flat[IX_MVOL*DATA_W +: DATA_W];
  assign master_mute    = master_vol[MUTE_BIT];
  assign dac_gain_mute  = regs_flat[IX_DACG*DATA_W + MUTE_BIT];
  assign enh_enable     = regs_flat[IX_GEN*DATA_W + ENH_BIT];
  assign enh_depth      = regs_flat[IX_DEPTH*DATA_W +: DEPTH_W];
  assign dac_rate       = use_alt_rate(mode_pins, codec_id) ? regs_flat[IX_RATEB*DATA_W +: DATA_W]
                                                            : regs_flat[IX_RATEA*DATA_W +: DATA_W];
  assign adc_rate       = regs_flat[IX_ADCR*DATA_W +: DATA_W];

  // R6: on an ID 10 part a surround write becomes the master volume
  a_r6_surround_master: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == reg_addr(IX_SURR) && codec_id == ID_SURR && $stable(codec_id))
      |=> (codec_id != ID_SURR) || (master_vol == $past(wr_data)));
  // R2: depth moves only on a write to its own register
  a_r2_depth_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_addr == reg_addr(IX_DEPTH)) |=> $stable(enh_depth));
endmodule

// File: tb/codec_regfile_bench.sv
module codec_regfile_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode_pins = 2'b00;
  logic [1:0]  codec_id = 2'b00;
  logic        wr_en = 1'b0;
  logic [6:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [6:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic        rd_valid;
  logic        enh_enable;
  logic [3:0]  enh_depth;
  logic [15:0] master_vol;
  logic        master_mute;
  logic        dac_gain_mute;
  logic [15:0] dac_rate;
  logic [15:0] adc_rate;

  int checks = 0;
  int errors = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;

  codec_regfile u_codec_regfile (
    .clk(clk), .rst_n(rst_n), .mode_pins(mode_pins), .codec_id(codec_id),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .rd_valid(rd_valid),
    .enh_enable(enh_enable), .enh_depth(enh_depth), .master_vol(master_vol),
    .master_mute(master_mute), .dac_gain_mute(dac_gain_mute),
    .dac_rate(dac_rate), .adc_rate(adc_rate));

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_write(input logic [6:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_read(input logic [6:0] a, input logic [15:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    @(negedge clk);
  endtask

  // monitor: pops expected answers as valid reads appear (R10)
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R10 unexpected read answer actual %h expected none", rd_data);
      end else begin
        string t;
        logic [15:0] e;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, rd_data, e);
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 during reset
    check("R1 mute in reset", {15'b0, master_mute}, 16'h1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 master_mute", {15'b0, master_mute}, 16'h1);
    check("R1 dac_gain_mute", {15'b0, dac_gain_mute}, 16'h1);
    check("R1 master_vol", master_vol, 16'h8000);
    check("R1 enh_enable", {15'b0, enh_enable}, 16'h0);
    check("R1 enh_depth", {12'b0, enh_depth}, 16'h0);
    check("R1 dac_rate", dac_rate, 16'hBB80);
    check("R1 adc_rate", adc_rate, 16'hBB80);
    check("R10 idle rd_valid", {15'b0, rd_valid}, 16'h0);
    do_read(7'h18, 16'h8808, "R1 read 18h");
    do_read(7'h38, 16'h8000, "R1 read 38h");

    // R2 depth
    do_write(7'h22, 16'hFFF9);
    check("R2 depth 9", {12'b0, enh_depth}, 16'h9);
    do_read(7'h22, 16'h0009, "R2 read 22h");
    do_write(7'h02, 16'h1234);
    check("R2 depth held", {12'b0, enh_depth}, 16'h9);
    do_write(7'h22, 16'h000F);
    check("R2 depth max", {12'b0, enh_depth}, 16'hF);

    // R3 general word
    do_read(7'h20, 16'h8000, "R3 POP default");
    do_write(7'h20, 16'h2000);
    check("R3 enh_enable", {15'b0, enh_enable}, 16'h1);
    do_read(7'h20, 16'hA000, "R3 read with enable");
    do_write(7'h20, 16'h5A5A);
    do_read(7'h20, 16'hDA5A, "R3 POP forced");
    check("R3 enh_enable off", {15'b0, enh_enable}, 16'h0);

    // R4 identity word
    do_read(7'h00, 16'h6000, "R4 identity");
    do_write(7'h00, 16'hFFFF);
    do_read(7'h00, 16'h6000, "R4 identity after write");

    // R5 ID echo
    do_read(7'h28, 16'h0000, "R5 id 00");
    do_write(7'h28, 16'hFFFF);
    codec_id = 2'b11;
    do_read(7'h28, 16'hC000, "R5 id 11");

    // R6 master source
    codec_id = 2'b00;
    do_write(7'h02, 16'h1F1F);
    check("R6 master from 02h", master_vol, 16'h1F1F);
    check("R6 master unmuted", {15'b0, master_mute}, 16'h0);
    do_write(7'h38, 16'h8A0A);
    check("R6 id00 ignores 38h", master_vol, 16'h1F1F);
    check("R7 id00 no override", {15'b0, dac_gain_mute}, 16'h1);
    codec_id = 2'b10;
    @(negedge clk);
    check("R6 master from 38h", master_vol, 16'h8A0A);
    check("R6 master muted", {15'b0, master_mute}, 16'h1);

    // R7 override
    do_write(7'h38, 16'h0505);
    check("R6 master new surr", master_vol, 16'h0505);
    check("R7 override clears", {15'b0, dac_gain_mute}, 16'h0);
    do_read(7'h18, 16'h0808, "R7 read 18h");
    do_write(7'h18, 16'h8808);
    check("R7 remute", {15'b0, dac_gain_mute}, 16'h1);
    codec_id = 2'b01;
    do_write(7'h38, 16'h0000);
    check("R7 id01 no override", {15'b0, dac_gain_mute}, 16'h1);

    // R8 rates
    do_write(7'h2C, 16'h5622);
    do_write(7'h2E, 16'h7D00);
    do_write(7'h32, 16'hAC44);
    mode_pins = 2'b00; codec_id = 2'b01;
    @(negedge clk);
    check("R8 mode00 id01", dac_rate, 16'h5622);
    mode_pins = 2'b10;
    @(negedge clk);
    check("R8 mode10 id01", dac_rate, 16'h7D00);
    mode_pins = 2'b00; codec_id = 2'b10;
    @(negedge clk);
    check("R8 mode00 id10", dac_rate, 16'h7D00);
    mode_pins = 2'b10; codec_id = 2'b00;
    @(negedge clk);
    check("R8 mode10 id00", dac_rate, 16'h5622);
    check("R8 adc_rate", adc_rate, 16'hAC44);

    // R9 unmapped
    codec_id = 2'b00;
    do_read(7'h10, 16'h0000, "R9 unmapped read");
    do_read(7'h03, 16'h0000, "R9 odd read");
    do_write(7'h03, 16'hFFFF);
    do_write(7'h10, 16'hFFFF);
    do_write(7'h23, 16'h0001);
    do_read(7'h02, 16'h1F1F, "R9 02h untouched");
    do_read(7'h10, 16'h0000, "R9 unmapped after write");
    check("R9 master unchanged", master_vol, 16'h1F1F);
    check("R9 depth unchanged", {12'b0, enh_depth}, 16'hF);

    @(negedge clk);
    check("R10 no pending reads", exp_q.size(), 16'h0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual running expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule